// File: doc/BRIEF.md
# Idle-Gap Framed Serial Receiver

This block receives asynchronous serial characters and groups them into frames. A frame closes when the line has stayed idle for a programmable number of bit times. Each accepted byte goes into a data queue. When a frame closes, its byte count goes into a separate count queue. Software first pops a frame's count and then pops exactly that many bytes.

A four-word register port carries several functions. It holds the configuration: the oversampling divisor, parity enable and sense, a receive enable and the idle-gap length. It reports how many frames and bytes are waiting, and it exposes sticky overrun, character-error and underrun flags. Software must issue a soft reset after it writes the configuration and before it first uses the block. The soft reset empties both queues and clears the partial-frame state.

Top module: `pkt_uart_rx`

Register map. All reads return their value on `bus_rdata` one cycle after `bus_rd`.

- **Address 0, CTRL** (read/write). Bits [15:0] hold the clock divisor for the 16x sample tick; a value of 0 acts as 1. Bit 16 enables parity. Bit 17 selects odd parity (0 selects even). Bit 18 enables receive. Bits [31:24] hold the idle gap in bit times. Reset value: divisor 1, parity on, even parity, receive off, gap 20.
- **Address 1, STATUS**. Bits [7:0] give the number of frames waiting. Bits [15:8] give the number of bytes waiting. Bit 16 is overrun, bit 17 is character error and bit 18 is underrun. Writing 1 to bit 16, 17 or 18 clears that flag. Writing 1 to bit 31 performs the soft reset.
- **Address 2, COUNT**. A read pops the oldest frame byte count.
- **Address 3, DATA**. A read pops the oldest byte.

## Requirements
- R1: After hardware reset, STATUS reads 0.
- R2: A character is a low start bit, 8 data bits sent LSB first, an optional parity bit and a high stop bit. The parity bit is even when CTRL[17]=0 and odd when CTRL[17]=1. The popped byte equals the byte that was sent.
- R3: A low pulse shorter than half a bit time is not taken as a start bit. It produces no byte and no frame.
- R4: A frame closes once the line has been idle for CTRL[31:24] bit times, counted from the middle of the last stop bit. Characters separated by fewer idle bit times join the same frame.
- R5: Each closed frame adds one entry to the count queue, holding the number of bytes stored for that frame. STATUS[7:0] counts the waiting frames, and a COUNT pop decreases it by one.
- R6: A character with a parity error or a low stop bit is dropped and sets sticky STATUS[17]. Writing 1 to bit 17 clears it.
- R7: A byte that arrives while the data queue is full is dropped and sets sticky STATUS[16]. A frame count that arrives while the count queue is full is also dropped and sets STATUS[16].
- R8: A pop of an empty queue returns 0, moves no pointer and sets sticky STATUS[18].
- R9: With CTRL[18]=0, the line is ignored: no bytes, no frames and no flags.
- R10: Writing 1 to STATUS[31] empties both queues, discards the partial frame and clears all flags.
- R11: An idle high line produces no frames and no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops on COUNT and DATA |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |

## Verification
The hardest condition to reach is a data-queue overrun in the middle of a frame. To get there, the queue must be full while the frame is still open, so the characters must arrive back to back with no gap long enough to close the frame. The stimulus sends one unbroken burst two bytes longer than the queue. It then checks that the frame count equals the queue depth and that the last two bytes are missing. Randomised frames with random lengths and inter-character gaps shorter than the idle gap exercise frame joining. Separate directed gaps just over the threshold exercise frame splitting.

// File: rtl/prx_pkg.sv
package prx_pkg;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_CNT  = 2'd2;
   localparam logic [1:0] A_DATA = 2'd3;
   localparam int B_OVR  = 16;
   localparam int B_CERR = 17;
   localparam int B_UND  = 18;
   localparam int B_SRST = 31;

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_st_e;

   typedef struct packed {
      logic [7:0]  gap;
      logic [4:0]  rsv;
      logic        en;
      logic        odd;
      logic        par;
      logic [15:0] div;
   } ctrl_t;
endpackage

// File: rtl/prx_fifo.sv
module prx_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty,
   output logic [AW:0]  level
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("prx_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_push, do_pop;

   assign full    = (level == (AW+1)'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0; rptr <= '0; level <= '0;
      end else if (clr) begin
         wptr <= '0; rptr <= '0; level <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> (level == $past(level)));
   p_empty_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !clr) |=> (rptr == $past(rptr)));
endmodule

// File: rtl/prx_bitrx.sv
module prx_bitrx import prx_pkg::*; (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        rx_async,
   input  logic        rx_en,
   input  logic [15:0] div,
   input  logic        par_en,
   input  logic        par_odd,
   output logic        tick,
   output logic        busy,
   output logic        line_hi,
   output logic        byte_vld,
   output logic        byte_err,
   output logic [7:0]  byte_out
);
   logic [1:0]  sy;
   logic [15:0] dcnt, div_m1;
   rx_st_e      st;
   logic [3:0]  sub;
   logic [2:0]  bitn;
   logic        perr;

   assign line_hi = sy[1];
   assign busy    = (st != S_IDLE);
   assign div_m1  = (div == 16'd0) ? 16'd0 : div - 16'd1;
   assign tick    = (dcnt >= div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sy <= 2'b11; dcnt <= '0;
      end else begin
         sy   <= {sy[0], rx_async};
         dcnt <= tick ? 16'd0 : dcnt + 16'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; sub <= '0; bitn <= '0; perr <= 1'b0;
         byte_vld <= 1'b0; byte_err <= 1'b0; byte_out <= '0;
      end else if (clr || !rx_en) begin
         st <= S_IDLE; sub <= '0; byte_vld <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         if (tick) begin
            case (st)
               S_IDLE: if (!line_hi) begin st <= S_START; sub <= '0; end
               S_START: begin
                  if (sub == 4'd7) begin
                     sub  <= '0; bitn <= '0; perr <= 1'b0;
                     st   <= line_hi ? S_IDLE : S_DATA;
                  end else sub <= sub + 4'd1;
               end
               S_DATA: begin
                  if (sub == 4'd15) begin
                     sub      <= '0;
                     byte_out <= {line_hi, byte_out[7:1]};
                     if (bitn == 3'd7) st <= par_en ? S_PAR : S_STOP;
                     else bitn <= bitn + 3'd1;
                  end else sub <= sub + 4'd1;
               end
               S_PAR: begin
                  if (sub == 4'd15) begin
                     sub  <= '0;
                     perr <= ((^byte_out) ^ line_hi) != par_odd;
                     st   <= S_STOP;
                  end else sub <= sub + 4'd1;
               end
               S_STOP: begin
                  if (sub == 4'd15) begin
                     sub      <= '0;
                     byte_vld <= 1'b1;
                     byte_err <= perr | !line_hi;
                     st       <= S_IDLE;
                  end else sub <= sub + 4'd1;
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !byte_vld);
   p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);
endmodule

// File: rtl/pkt_uart_rx.sv
module pkt_uart_rx import prx_pkg::*; #(
   parameter int DATA_DEPTH = 16,
   parameter int CNT_DEPTH  = 4,
   parameter int CNT_W      = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_line,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata
);
   localparam int DAW = $clog2(DATA_DEPTH);
   localparam int CAW = $clog2(CNT_DEPTH);

   generate
      if (DAW + 1 > 8 || CAW + 1 > 8) begin : g_bad_lvl
         $error("pkt_uart_rx: queue depth too large for STATUS fields");
      end
      if (CNT_W < DAW + 1 || CNT_W > 32) begin : g_bad_cw
         $error("pkt_uart_rx: CNT_W out of range");
      end
   endgenerate

   ctrl_t        ctrl;
   logic         srst;
   logic         tick, busy, line_hi, bvld, berr;
   logic [7:0]   bbyte;
   logic         d_push, d_pop, d_full, d_empty;
   logic [7:0]   d_dout;
   logic [DAW:0] d_lvl;
   logic         c_pop, c_full, c_empty;
   logic [CNT_W-1:0] c_dout, frm_n;
   logic [CAW:0] c_lvl;
   logic [11:0]  gap_cnt, gap_ticks;
   logic         open_frm, close;
   logic         f_ovr, f_cerr, f_und;
   logic [31:0]  stat_w;

   assign srst      = bus_wr && (bus_addr == A_STAT) && bus_wdata[B_SRST];
   assign d_push    = bvld && !berr;
   assign d_pop     = bus_rd && (bus_addr == A_DATA);
   assign c_pop     = bus_rd && (bus_addr == A_CNT);
   assign open_frm  = (frm_n != '0);
   assign gap_ticks = {ctrl.gap, 4'b0000};
   assign close     = tick && open_frm && !busy && line_hi &&
                      (({1'b0, gap_cnt} + 13'd1) >= {1'b0, gap_ticks});

   prx_bitrx u_bit (
      .clk(clk), .rst_n(rst_n), .clr(srst), .rx_async(rx_line),
      .rx_en(ctrl.en), .div(ctrl.div), .par_en(ctrl.par), .par_odd(ctrl.odd),
      .tick(tick), .busy(busy), .line_hi(line_hi),
      .byte_vld(bvld), .byte_err(berr), .byte_out(bbyte));

   prx_fifo #(.W(8), .DEPTH(DATA_DEPTH)) u_dq (
      .clk(clk), .rst_n(rst_n), .clr(srst), .push(d_push), .din(bbyte),
      .pop(d_pop), .dout(d_dout), .full(d_full), .empty(d_empty), .level(d_lvl));

   prx_fifo #(.W(CNT_W), .DEPTH(CNT_DEPTH)) u_cq (
      .clk(clk), .rst_n(rst_n), .clr(srst), .push(close), .din(frm_n),
      .pop(c_pop), .dout(c_dout), .full(c_full), .empty(c_empty), .level(c_lvl));

   // frame assembly: byte tally and idle-gap timer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt <= '0; frm_n <= '0;
      end else if (srst) begin
         gap_cnt <= '0; frm_n <= '0;
      end else begin
         if (busy || !line_hi)      gap_cnt <= '0;
         else if (tick && open_frm) gap_cnt <= close ? 12'd0 : gap_cnt + 12'd1;
         if (close)                 frm_n <= '0;
         else if (d_push && !d_full) frm_n <= frm_n + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '{gap: 8'd20, rsv: '0, en: 1'b0, odd: 1'b0, par: 1'b1, div: 16'd1};
         f_ovr <= 1'b0; f_cerr <= 1'b0; f_und <= 1'b0;
      end else begin
         if (bus_wr && bus_addr == A_CTRL) ctrl <= ctrl_t'(bus_wdata);
         if (srst) begin
            f_ovr <= 1'b0; f_cerr <= 1'b0; f_und <= 1'b0;
         end else begin
            if ((d_push && d_full) || (close && c_full)) f_ovr <= 1'b1;
            else if (bus_wr && bus_addr == A_STAT && bus_wdata[B_OVR]) f_ovr <= 1'b0;
            if (bvld && berr) f_cerr <= 1'b1;
            else if (bus_wr && bus_addr == A_STAT && bus_wdata[B_CERR]) f_cerr <= 1'b0;
            if ((c_pop && c_empty) || (d_pop && d_empty)) f_und <= 1'b1;
            else if (bus_wr && bus_addr == A_STAT && bus_wdata[B_UND]) f_und <= 1'b0;
         end
      end
   end

   always_comb begin
      stat_w         = '0;
      stat_w[7:0]    = 8'(c_lvl);
      stat_w[15:8]   = 8'(d_lvl);
      stat_w[B_OVR]  = f_ovr;
      stat_w[B_CERR] = f_cerr;
      stat_w[B_UND]  = f_und;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else if (bus_rd) begin
         case (bus_addr)
            A_CTRL:  bus_rdata <= ctrl;
            A_STAT:  bus_rdata <= stat_w;
            A_CNT:   bus_rdata <= c_empty ? 32'd0 : 32'(c_dout);
            default: bus_rdata <= d_empty ? 32'd0 : 32'(d_dout);
         endcase
      end
   end

   p_frames_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_pop && !c_empty && !close && !srst) |=> (c_lvl == $past(c_lvl) - 1'b1));
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (f_cerr && !srst && !(bus_wr && bus_addr == A_STAT && bus_wdata[B_CERR])) |=> f_cerr);
   p_underrun_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_DATA && d_empty) |=> (bus_rdata == 32'd0));
   p_srst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (c_lvl == '0 && d_lvl == '0 && !f_ovr && !f_und));
endmodule

// File: tb/pkt_uart_rx_tb.sv
`timescale 1ns/1ps
module pkt_uart_rx_tb;
   localparam int BIT = 32;          // divisor 2 -> 32 clocks per bit
   localparam int GAP = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_line = 1'b1;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   bit cur_odd = 0;

   always #4 clk = ~clk;

   pkt_uart_rx u_dut (.clk(clk), .rst_n(rst_n), .rx_line(rx_line),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   function automatic logic [31:0] cfg(bit en, bit odd);
      return (32'(GAP) << 24) | (32'(en) << 18) | (32'(odd) << 17) | (32'd1 << 16) | 32'd2;
   endfunction

   function automatic logic exp_par(logic [7:0] b, bit odd);
      return (^b) ^ odd;
   endfunction

   function automatic logic [31:0] stat(int frames, int bytes, bit ovr, bit cerr, bit und);
      return 32'(frames) | (32'(bytes) << 8) | (32'(ovr) << 16) | (32'(cerr) << 17) | (32'(und) << 18);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1; bus_addr = a;
      @(negedge clk); bus_rd = 0; d = bus_rdata;
   endtask

   task automatic idle(int nbits);
      rx_line = 1'b1;
      repeat (nbits * BIT) @(negedge clk);
   endtask

   task automatic send(logic [7:0] b, bit bad);
      @(negedge clk); rx_line = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_line = b[i];
         repeat (BIT) @(negedge clk);
      end
      rx_line = exp_par(b, cur_odd) ^ bad;
      repeat (BIT) @(negedge clk);
      rx_line = 1'b1;
      repeat (BIT) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  q[$];
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      rd(2'd1, v); chk("R1 status after reset", v, 32'd0);
      rd(2'd2, v); chk("R8 empty count pop", v, 32'd0);
      rd(2'd3, v); chk("R8 empty data pop", v, 32'd0);
      rd(2'd1, v); chk("R8 underrun flag", v, stat(0, 0, 0, 0, 1));
      wr(2'd1, 32'h0007_0000);
      rd(2'd1, v); chk("R8 underrun cleared", v, 32'd0);

      wr(2'd0, cfg(1, 0));
      wr(2'd1, 32'h8000_0000);
      idle(60);
      rd(2'd1, v); chk("R11 idle line", v, 32'd0);

      // R3 short low glitch
      @(negedge clk); rx_line = 1'b0;
      repeat (10) @(negedge clk);
      idle(40);
      rd(2'd1, v); chk("R3 glitch ignored", v, 32'd0);

      // R4 join: two chars with short idle form one frame
      send(8'hA5, 0); idle(2); send(8'h3C, 0); idle(GAP + 2);
      rd(2'd1, v); chk("R4 joined frame", v, stat(1, 2, 0, 0, 0));
      rd(2'd2, v); chk("R5 frame count", v, 32'd2);
      rd(2'd1, v); chk("R5 frames decrement", v, stat(0, 2, 0, 0, 0));
      rd(2'd3, v); chk("R2 byte 0", v, 32'hA5);
      rd(2'd3, v); chk("R2 byte 1", v, 32'h3C);

      // R4 split: idle longer than gap makes two frames
      send(8'h11, 0); idle(GAP + 4); send(8'h22, 0); idle(GAP + 4);
      rd(2'd1, v); chk("R4 split frames", v, stat(2, 2, 0, 0, 0));
      rd(2'd2, v); chk("R4 count a", v, 32'd1);
      rd(2'd3, v); chk("R4 byte a", v, 32'h11);
      rd(2'd2, v); chk("R4 count b", v, 32'd1);
      rd(2'd3, v); chk("R4 byte b", v, 32'h22);

      // random frames
      for (int f = 0; f < 20; f++) begin
         int len;
         len = 1 + int'($urandom % 5);
         q.delete();
         for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            q.push_back(b);
            send(b, 0);
            idle(int'($urandom % 4));
         end
         idle(GAP + 2);
         rd(2'd2, v); chk("R5 random count", v, 32'(len));
         for (int i = 0; i < len; i++) begin
            rd(2'd3, v); chk("R2 random byte", v, 32'(q[i]));
         end
      end

      // R6 parity error
      send(8'h55, 1); idle(GAP + 2);
      rd(2'd1, v); chk("R6 parity error flag", v, stat(0, 0, 0, 1, 0));
      wr(2'd1, 32'h0002_0000);
      rd(2'd1, v); chk("R6 flag cleared", v, 32'd0);

      // R2 odd parity
      wr(2'd0, cfg(1, 1)); cur_odd = 1;
      send(8'h0F, 0); idle(GAP + 2);
      rd(2'd2, v); chk("R2 odd count", v, 32'd1);
      rd(2'd3, v); chk("R2 odd byte", v, 32'h0F);
      send(8'h0F, 1); idle(GAP + 2);
      rd(2'd1, v); chk("R2 odd wrong parity", v, stat(0, 0, 0, 1, 0));
      wr(2'd1, 32'h0002_0000);
      wr(2'd0, cfg(1, 0)); cur_odd = 0;

      // R7 data queue overrun mid-frame
      for (int i = 0; i < 18; i++) send(8'(8'h40 + i), 0);
      idle(GAP + 2);
      rd(2'd1, v); chk("R7 overrun status", v, stat(1, 16, 1, 0, 0));
      rd(2'd2, v); chk("R7 count", v, 32'd16);
      for (int i = 0; i < 16; i++) begin
         rd(2'd3, v); chk("R7 kept byte", v, 32'(8'h40 + i));
      end
      wr(2'd1, 32'h0001_0000);
      rd(2'd1, v); chk("R7 overrun cleared", v, 32'd0);

      // R10 soft reset
      send(8'h77, 0); send(8'h88, 0); idle(GAP + 2);
      rd(2'd1, v); chk("R10 before reset", v, stat(1, 2, 0, 0, 0));
      wr(2'd1, 32'h8000_0000);
      rd(2'd1, v); chk("R10 after reset", v, 32'd0);
      rd(2'd3, v); chk("R10 data empty", v, 32'd0);
      wr(2'd1, 32'h8000_0000);

      // R9 receive disabled
      wr(2'd0, cfg(0, 0));
      send(8'h99, 0); send(8'h66, 1); idle(GAP + 2);
      rd(2'd1, v); chk("R9 masked", v, 32'd0);
      wr(2'd0, cfg(1, 0));
      send(8'h5A, 0); idle(GAP + 2);
      rd(2'd2, v); chk("R9 reenabled count", v, 32'd1);
      rd(2'd3, v); chk("R9 reenabled byte", v, 32'h5A);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule